// File: doc/BRIEF.md
# Remote-Tag Cache Access Sequencer

This block is the device-side sequencer that serves one read or write command at a time through two caches: an address-translation cache and a write-buffer cache. Neither cache keeps its tags or lines in local RAM. Both live in memory on the far side of a request/response link. Every tag check therefore costs a round trip over that link. The block itself holds only a small local copy of the translation tags, one entry per set.

For each accepted command the sequencer can run a translation step, selected per command. That step reads the remote translation tag and compares it with the local copy. On a match it fetches the translation line. On a mismatch it rewrites the remote tag and line, but only when the local copy was refreshed for this command. The sequencer then reads the remote write-buffer tag and classifies the access as a hit, a miss, or a conflict with a dirty line.

The outcome is issued as single-cycle operation strobes, each acknowledged by a completion input:
- flush of a dirty victim line to non-volatile storage,
- fill of the remote buffer from system memory,
- copy from the remote buffer to system memory,
- direct return from the storage path.

A write ends by storing its new tag as valid and dirty. Every command ends with a one-cycle done pulse and a status code.

Top module: `rcache_seq`

## Requirements
- R1: `cmd_ready` is high only while the block is idle. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` stays low from the next cycle until the cycle after the done pulse.
- R2: The set index is `cmd_addr[SET_W-1:0]` and the address tag is `cmd_addr[ADDR_W-1:SET_W]`. With the translation step enabled (`cmd_xlat_en`=1), the first remote request is a read of the translation tag (`rq_sel`=0) at the set index. The write-buffer tag read (`rq_sel`=2) is issued only after the translation step has finished.
- R3: The translation step matches when both of these hold: the local copy entry for the set is valid, and the remote word has its valid bit (bit `ADDR_W-SET_W+1`) set with a tag field (low `ADDR_W-SET_W` bits) equal to the local tag. On a match the block reads the translation line (`rq_sel`=1) and issues no remote write.
- R4: A command with `cmd_xlat_en`=1 and `cmd_xlat_upd`=1 loads its address tag into the local copy when it is accepted. On a mismatch with `cmd_xlat_upd`=1, the block writes the tag and then the line to remote memory. Both words are valid=1, dirty=0 with the address tag. On a mismatch with `cmd_xlat_upd`=0 it writes nothing.
- R5: With `cmd_xlat_en`=0, the first remote request of the command is the write-buffer tag read.
- R6: A write whose write-buffer word is valid and dirty with a different tag raises `op_flush` with `op_tag` set to the victim tag. `op_fill` is not raised until `op_done` has acknowledged the flush.
- R7: Every write raises `op_fill` and, after its `op_done`, writes the write-buffer tag word as valid=1, dirty=1 with the new address tag.
- R8: A read whose write-buffer word is valid with an equal tag raises `op_copy_out`; any other read raises `op_direct`. A read never writes the write-buffer tag.
- R9: `done` is a one-cycle pulse. `done_status` is 1 for a write-buffer hit, 2 for a miss, and 3 for a write that needed a flush.
- R10: While `rq_valid` is high and `rq_ready` low, `rq_valid` and all request fields hold steady. No new request is raised while a response is outstanding.
- R11: Operation strobes last one cycle and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_write | input | 1 | 1 = write command, 0 = read |
| cmd_addr | input | ADDR_W | Logical address |
| cmd_xlat_en | input | 1 | Run the translation step for this command |
| cmd_xlat_upd | input | 1 | Local translation copy refreshed for this command |
| rq_valid | output | 1 | Remote request valid |
| rq_ready | input | 1 | Remote request accepted |
| rq_write | output | 1 | 1 = remote write, 0 = remote read |
| rq_sel | output | 2 | Region: 0 translation tag, 1 translation line, 2 write-buffer tag |
| rq_index | output | SET_W | Set index |
| rq_wdata | output | ADDR_W-SET_W+2 | Write word {valid, dirty, tag} |
| rs_valid | input | 1 | Remote response (read data or write acknowledge) |
| rs_data | input | ADDR_W-SET_W+2 | Read response word |
| op_flush | output | 1 | Flush victim line strobe |
| op_fill | output | 1 | Copy system memory into remote buffer strobe |
| op_copy_out | output | 1 | Copy remote buffer to system memory strobe |
| op_direct | output | 1 | Return data from storage path strobe |
| op_index | output | SET_W | Set of the issued operation |
| op_tag | output | ADDR_W-SET_W | Tag of the issued operation (victim tag for a flush) |
| op_done | input | 1 | Completion of the outstanding operation |
| done | output | 1 | Command finished pulse |
| done_status | output | 2 | 1 hit, 2 miss, 3 flushed-then-written |

## Verification
A remote request appears in the cycle after the block enters the step that needs it. The block moves on one cycle after `rs_valid`. An operation strobe appears two cycles after the write-buffer response, since the fire step and its output register each add a cycle. `done` rises one cycle after the final response or `op_done`. The bench therefore never samples at a fixed offset. It logs every handshake and strobe at the clock edge where it occurs, then, at falling edges, waits for `done` and compares the ordered event log, the captured victim tag and the final remote-memory words with the expected values. Request stability, outstanding-response and strobe-width rules are watched on every edge by the bench's monitors, and the bench varies `rq_ready` so that stalls occur.

// File: rtl/rcache_pkg.sv
package rcache_pkg;

   typedef enum logic [1:0] {
      REG_XTAG  = 2'd0,
      REG_XLINE = 2'd1,
      REG_WTAG  = 2'd2
   } region_e;

   typedef enum logic [1:0] {
      ST_NONE    = 2'd0,
      ST_HIT     = 2'd1,
      ST_MISS    = 2'd2,
      ST_FLUSHED = 2'd3
   } status_e;

   typedef enum logic [1:0] {
      OP_FLUSH   = 2'd0,
      OP_FILL    = 2'd1,
      OP_COPYOUT = 2'd2,
      OP_DIRECT  = 2'd3
   } op_kind_e;

   typedef enum logic [4:0] {
      S_IDLE, S_XT_RD, S_XT_RSP, S_XL_RD, S_XL_RSP,
      S_XT_WR, S_XT_WRSP, S_XL_WR, S_XL_WRSP,
      S_WB_RD, S_WB_RSP, S_FLUSH, S_FLUSH_W,
      S_DATA, S_DATA_W, S_WB_WR, S_WB_WRSP, S_DONE
   } seq_state_e;

endpackage

// File: rtl/rcache_local_copy.sv
module rcache_local_copy #(
   parameter int SETS    = 8,
   parameter int SET_W   = 3,
   parameter int TAG_W   = 13,
   parameter bit PRESENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [SET_W-1:0] ld_idx,
   input  logic [TAG_W-1:0] ld_tag,
   input  logic [SET_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag
);

   if (SETS != (1 << SET_W)) begin : g_bad_sets
      $error("rcache_local_copy: SETS must equal 2**SET_W");
   end

   if (PRESENT) begin : g_store
      logic [SETS-1:0]  ent_v;
      logic [TAG_W-1:0] ent_t [SETS];

      for (genvar i = 0; i < SETS; i++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent_v[i] <= 1'b0;
               ent_t[i] <= '0;
            end else if (ld && (ld_idx == SET_W'(i))) begin
               ent_v[i] <= 1'b1;
               ent_t[i] <= ld_tag;
            end
         end
      end

      assign rd_valid = ent_v[rd_idx];
      assign rd_tag   = ent_t[rd_idx];
   end else begin : g_none
      assign rd_valid = 1'b0;
      assign rd_tag   = '0;
   end

endmodule

// File: rtl/rcache_tag_eval.sv
module rcache_tag_eval #(
   parameter int TAG_W = 13
) (
   input  logic [TAG_W+1:0] word,
   input  logic [TAG_W-1:0] addr_tag,
   input  logic             loc_valid,
   input  logic [TAG_W-1:0] loc_tag,
   output logic             xlat_match,
   output logic             wb_hit,
   output logic             wb_conflict
);

   localparam int V_BIT = TAG_W + 1;
   localparam int D_BIT = TAG_W;

   logic             w_valid;
   logic             w_dirty;
   logic [TAG_W-1:0] w_tag;

   assign w_valid = word[V_BIT];
   assign w_dirty = word[D_BIT];
   assign w_tag   = word[TAG_W-1:0];

   always_comb begin
      xlat_match  = loc_valid && w_valid && (w_tag == loc_tag);
      wb_hit      = w_valid && (w_tag == addr_tag);
      wb_conflict = w_valid && w_dirty && (w_tag != addr_tag);
   end

endmodule

// File: rtl/rcache_op_issue.sv
module rcache_op_issue
   import rcache_pkg::*;
#(
   parameter int SET_W = 3,
   parameter int TAG_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  op_kind_e         kind,
   input  logic [SET_W-1:0] idx_in,
   input  logic [TAG_W-1:0] tag_in,
   input  logic             op_done,
   output logic             op_flush,
   output logic             op_fill,
   output logic             op_copy_out,
   output logic             op_direct,
   output logic [SET_W-1:0] op_index,
   output logic [TAG_W-1:0] op_tag
);

   localparam int NKIND = 4;

   logic [NKIND-1:0] strb_q;
   logic             flush_open;

   for (genvar k = 0; k < NKIND; k++) begin : g_strb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) strb_q[k] <= 1'b0;
         else        strb_q[k] <= fire && (kind == op_kind_e'(k));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_index <= '0;
         op_tag   <= '0;
      end else if (fire) begin
         op_index <= idx_in;
         op_tag   <= tag_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flush_open <= 1'b0;
      else if (op_flush) flush_open <= 1'b1;
      else if (op_done)  flush_open <= 1'b0;
   end

   assign op_flush    = strb_q[OP_FLUSH];
   assign op_fill     = strb_q[OP_FILL];
   assign op_copy_out = strb_q[OP_COPYOUT];
   assign op_direct   = strb_q[OP_DIRECT];

   // R11
   strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strb_q));

   // R11
   strb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_q != '0) |=> (strb_q == '0));

   // R6
   fill_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_fill |-> !flush_open);

endmodule

// File: rtl/rcache_seq.sv
module rcache_seq
   import rcache_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int SET_W        = 3,
   parameter bit XLAT_PRESENT = 1'b1,
   localparam int TAG_W       = ADDR_W - SET_W,
   localparam int WORD_W      = TAG_W + 2,
   localparam int SETS        = 1 << SET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              cmd_xlat_en,
   input  logic              cmd_xlat_upd,
   output logic              rq_valid,
   input  logic              rq_ready,
   output logic              rq_write,
   output logic [1:0]        rq_sel,
   output logic [SET_W-1:0]  rq_index,
   output logic [WORD_W-1:0] rq_wdata,
   input  logic              rs_valid,
   input  logic [WORD_W-1:0] rs_data,
   output logic              op_flush,
   output logic              op_fill,
   output logic              op_copy_out,
   output logic              op_direct,
   output logic [SET_W-1:0]  op_index,
   output logic [TAG_W-1:0]  op_tag,
   input  logic              op_done,
   output logic              done,
   output logic [1:0]        done_status
);

   if (SET_W < 1 || SET_W > 12) begin : g_bad_setw
      $error("rcache_seq: SET_W out of range");
   end
   if (TAG_W < 1) begin : g_bad_tagw
      $error("rcache_seq: ADDR_W must exceed SET_W");
   end

   seq_state_e       state_q, state_d;
   logic             wr_q, upd_q, xen_q, hit_q;
   logic [SET_W-1:0] idx_q;
   logic [TAG_W-1:0] tag_q, victim_q;
   status_e          stat_q;

   logic             accept;
   logic             loc_valid;
   logic [TAG_W-1:0] loc_tag;
   logic             xlat_match, wb_hit, wb_conflict;
   logic             fire;
   op_kind_e         fire_kind;
   logic [TAG_W-1:0] fire_tag;

   assign cmd_ready = (state_q == S_IDLE);
   assign accept    = cmd_valid && cmd_ready;

   rcache_local_copy #(
      .SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W), .PRESENT(XLAT_PRESENT)
   ) u_loc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (accept && cmd_xlat_en && cmd_xlat_upd),
      .ld_idx   (cmd_addr[SET_W-1:0]),
      .ld_tag   (cmd_addr[ADDR_W-1:SET_W]),
      .rd_idx   (idx_q),
      .rd_valid (loc_valid),
      .rd_tag   (loc_tag)
   );

   rcache_tag_eval #(.TAG_W(TAG_W)) u_eval (
      .word        (rs_data),
      .addr_tag    (tag_q),
      .loc_valid   (loc_valid),
      .loc_tag     (loc_tag),
      .xlat_match  (xlat_match),
      .wb_hit      (wb_hit),
      .wb_conflict (wb_conflict)
   );

   always_comb begin
      fire      = (state_q == S_FLUSH) || (state_q == S_DATA);
      fire_tag  = (state_q == S_FLUSH) ? victim_q : tag_q;
      if (state_q == S_FLUSH)  fire_kind = OP_FLUSH;
      else if (wr_q)           fire_kind = OP_FILL;
      else if (hit_q)          fire_kind = OP_COPYOUT;
      else                     fire_kind = OP_DIRECT;
   end

   rcache_op_issue #(.SET_W(SET_W), .TAG_W(TAG_W)) u_ops (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (fire),
      .kind        (fire_kind),
      .idx_in      (idx_q),
      .tag_in      (fire_tag),
      .op_done     (op_done),
      .op_flush    (op_flush),
      .op_fill     (op_fill),
      .op_copy_out (op_copy_out),
      .op_direct   (op_direct),
      .op_index    (op_index),
      .op_tag      (op_tag)
   );

   // remote request fields derive from the step being served
   always_comb begin
      rq_valid = 1'b0;
      rq_write = 1'b0;
      rq_sel   = REG_XTAG;
      rq_wdata = '0;
      unique case (state_q)
         S_XT_RD: begin rq_valid = 1'b1; rq_sel = REG_XTAG;  end
         S_XL_RD: begin rq_valid = 1'b1; rq_sel = REG_XLINE; end
         S_WB_RD: begin rq_valid = 1'b1; rq_sel = REG_WTAG;  end
         S_XT_WR: begin
            rq_valid = 1'b1; rq_write = 1'b1; rq_sel = REG_XTAG;
            rq_wdata = {2'b10, tag_q};
         end
         S_XL_WR: begin
            rq_valid = 1'b1; rq_write = 1'b1; rq_sel = REG_XLINE;
            rq_wdata = {2'b10, tag_q};
         end
         S_WB_WR: begin
            rq_valid = 1'b1; rq_write = 1'b1; rq_sel = REG_WTAG;
            rq_wdata = {2'b11, tag_q};
         end
         default: ;
      endcase
   end
   assign rq_index = idx_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:
            if (accept) state_d = (XLAT_PRESENT && cmd_xlat_en) ? S_XT_RD : S_WB_RD;
         S_XT_RD:   if (rq_ready) state_d = S_XT_RSP;
         S_XT_RSP:
            if (rs_valid) begin
               if (xlat_match) state_d = S_XL_RD;
               else if (upd_q) state_d = S_XT_WR;
               else            state_d = S_WB_RD;
            end
         S_XL_RD:   if (rq_ready) state_d = S_XL_RSP;
         S_XL_RSP:  if (rs_valid) state_d = S_WB_RD;
         S_XT_WR:   if (rq_ready) state_d = S_XT_WRSP;
         S_XT_WRSP: if (rs_valid) state_d = S_XL_WR;
         S_XL_WR:   if (rq_ready) state_d = S_XL_WRSP;
         S_XL_WRSP: if (rs_valid) state_d = S_WB_RD;
         S_WB_RD:   if (rq_ready) state_d = S_WB_RSP;
         S_WB_RSP:
            if (rs_valid) state_d = (wr_q && wb_conflict) ? S_FLUSH : S_DATA;
         S_FLUSH:   state_d = S_FLUSH_W;
         S_FLUSH_W: if (op_done) state_d = S_DATA;
         S_DATA:    state_d = S_DATA_W;
         S_DATA_W:  if (op_done) state_d = wr_q ? S_WB_WR : S_DONE;
         S_WB_WR:   if (rq_ready) state_d = S_WB_WRSP;
         S_WB_WRSP: if (rs_valid) state_d = S_DONE;
         S_DONE:    state_d = S_IDLE;
         default:   state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         wr_q     <= 1'b0;
         upd_q    <= 1'b0;
         xen_q    <= 1'b0;
         hit_q    <= 1'b0;
         idx_q    <= '0;
         tag_q    <= '0;
         victim_q <= '0;
         stat_q   <= ST_NONE;
      end else begin
         state_q <= state_d;
         if (accept) begin
            wr_q  <= cmd_write;
            upd_q <= cmd_xlat_upd;
            xen_q <= cmd_xlat_en;
            idx_q <= cmd_addr[SET_W-1:0];
            tag_q <= cmd_addr[ADDR_W-1:SET_W];
         end
         if (state_q == S_WB_RSP && rs_valid) begin
            hit_q    <= wb_hit;
            victim_q <= rs_data[TAG_W-1:0];
            if (wr_q && wb_conflict) stat_q <= ST_FLUSHED;
            else if (wb_hit)         stat_q <= ST_HIT;
            else                     stat_q <= ST_MISS;
         end
      end
   end

   assign done        = (state_q == S_DONE);
   assign done_status = done ? stat_q : ST_NONE;

   // R1
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_status != 2'd0));

   // R10
   rq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && !rq_ready) |=>
         (rq_valid && $stable(rq_sel) && $stable(rq_write) &&
          $stable(rq_index) && $stable(rq_wdata)));

   // R5
   skip_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && !cmd_xlat_en) |=> (rq_sel == 2'd2));

   // R8
   read_no_wbwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && rq_write && rq_sel == 2'd2) |-> wr_q);

   // R4
   xlat_wr_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && rq_write && rq_sel != 2'd2) |-> (upd_q && xen_q));

endmodule

// File: tb/rcache_seq_tb.sv
module rcache_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 16;
   localparam int SW  = 3;
   localparam int TW  = AW - SW;
   localparam int WW  = TW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0, cmd_write = 1'b0;
   logic          cmd_xlat_en = 1'b0, cmd_xlat_upd = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic          cmd_ready;
   logic          rq_valid, rq_write;
   logic          rq_ready = 1'b0;
   logic [1:0]    rq_sel;
   logic [SW-1:0] rq_index;
   logic [WW-1:0] rq_wdata;
   logic          rs_valid = 1'b0;
   logic [WW-1:0] rs_data = '0;
   logic          op_flush, op_fill, op_copy_out, op_direct;
   logic [SW-1:0] op_index;
   logic [TW-1:0] op_tag;
   logic          op_done = 1'b0;
   logic          done;
   logic [1:0]    done_status;

   always #(CLK_PERIOD/2) clk = ~clk;

   rcache_seq #(.ADDR_W(AW), .SET_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_xlat_en(cmd_xlat_en), .cmd_xlat_upd(cmd_xlat_upd),
      .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_write(rq_write),
      .rq_sel(rq_sel), .rq_index(rq_index), .rq_wdata(rq_wdata),
      .rs_valid(rs_valid), .rs_data(rs_data),
      .op_flush(op_flush), .op_fill(op_fill), .op_copy_out(op_copy_out),
      .op_direct(op_direct), .op_index(op_index), .op_tag(op_tag),
      .op_done(op_done), .done(done), .done_status(done_status)
   );

   // event codes
   localparam int E_XT_RD = 1, E_XL_RD = 2, E_XT_WR = 3, E_XL_WR = 4;
   localparam int E_WB_RD = 5, E_WB_WR = 6, E_FLUSH = 7, E_FILL = 8;
   localparam int E_COPY = 9, E_DIRECT = 10;

   int n_chk = 0, n_fail = 0;
   int ev [16];
   int ev_n = 0;
   logic [TW-1:0] flush_tag_seen;
   logic [WW-1:0] m_xt [8];
   logic [WW-1:0] m_xl [8];
   logic [WW-1:0] m_wb [8];
   int  rdy_cnt = 0, op_cnt = 0, cyc = 0;
   logic outstanding = 1'b0;
   int  viol_hold = 0, viol_out = 0, viol_strb = 0;
   logic p_valid = 1'b0, p_ready = 1'b0, p_write = 1'b0;
   logic [1:0] p_sel = '0;
   logic [SW-1:0] p_idx = '0;
   logic [WW-1:0] p_wd = '0;
   logic [3:0] p_strb = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic log_ev(input int code);
      if (ev_n < 16) ev[ev_n] = code;
      ev_n++;
   endtask

   // remote memory, operation responder and protocol monitors
   always @(posedge clk) begin
      cyc++;
      if (rst_n) begin
         rdy_cnt++;
         rq_ready <= (rdy_cnt % 3) != 0;
         rs_valid <= 1'b0;
         if (rs_valid) outstanding <= 1'b0;
         if (rq_valid && outstanding && !rs_valid) viol_out++;
         if (p_valid && !p_ready &&
             !(rq_valid && rq_sel == p_sel && rq_write == p_write &&
               rq_index == p_idx && rq_wdata == p_wd)) viol_hold++;
         if (rq_valid && rq_ready) begin
            outstanding <= 1'b1;
            rs_valid    <= 1'b1;
            if (rq_write) begin
               case (rq_sel)
                  2'd0: begin m_xt[rq_index] = rq_wdata; log_ev(E_XT_WR); end
                  2'd1: begin m_xl[rq_index] = rq_wdata; log_ev(E_XL_WR); end
                  default: begin m_wb[rq_index] = rq_wdata; log_ev(E_WB_WR); end
               endcase
            end else begin
               case (rq_sel)
                  2'd0: begin rs_data <= m_xt[rq_index]; log_ev(E_XT_RD); end
                  2'd1: begin rs_data <= m_xl[rq_index]; log_ev(E_XL_RD); end
                  default: begin rs_data <= m_wb[rq_index]; log_ev(E_WB_RD); end
               endcase
            end
         end
         if (p_strb != 4'b0 && {op_flush, op_fill, op_copy_out, op_direct} != 4'b0)
            viol_strb++;
         if ($countones({op_flush, op_fill, op_copy_out, op_direct}) > 1) viol_strb++;
         if (op_flush) begin log_ev(E_FLUSH); flush_tag_seen = op_tag; end
         if (op_fill)     log_ev(E_FILL);
         if (op_copy_out) log_ev(E_COPY);
         if (op_direct)   log_ev(E_DIRECT);
         op_done <= 1'b0;
         if (op_flush || op_fill || op_copy_out || op_direct) op_cnt = 3;
         else if (op_cnt > 0) begin
            op_cnt--;
            if (op_cnt == 0) op_done <= 1'b1;
         end
         p_valid = rq_valid; p_ready = rq_ready; p_write = rq_write;
         p_sel = rq_sel; p_idx = rq_index; p_wd = rq_wdata;
         p_strb = {op_flush, op_fill, op_copy_out, op_direct};
      end
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // issue one command and wait for done; returns status
   task automatic run_cmd(input bit wr, input logic [AW-1:0] a, input bit xen,
                          input bit upd, input string req, output int st);
      bit busy_ok = 1'b1;
      int guard = 0;
      ev_n = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a;
      cmd_xlat_en = xen; cmd_xlat_upd = upd;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!done && guard < 2000) begin
         if (cmd_ready) busy_ok = 1'b0;
         @(negedge clk);
         guard++;
      end
      chk(guard < 2000, {req, " done reached"}, guard, 0);
      chk(busy_ok, "R1 cmd_ready low while busy", busy_ok, 1);
      st = int'(done_status);
      @(negedge clk);
      chk(!done, "R9 done lasts one cycle", done, 0);
      chk(cmd_ready, "R1 cmd_ready back after done", cmd_ready, 1);
   endtask

   task automatic chk_seq(input string req, input int e0, input int e1, input int e2,
                          input int e3, input int e4, input int e5);
      int exp [6];
      int cnt = 0;
      bit ok;
      exp = '{e0, e1, e2, e3, e4, e5};
      for (int i = 0; i < 6; i++) if (exp[i] > 0) cnt++;
      chk(ev_n == cnt, {req, " event count"}, ev_n, cnt);
      for (int i = 0; i < cnt && i < ev_n; i++) begin
         ok = (ev[i] == exp[i]);
         chk(ok, {req, " event order"}, ev[i], exp[i]);
      end
   endtask

   task automatic t_reset;
      chk(cmd_ready == 1'b1, "R1 reset cmd_ready", cmd_ready, 1);
      chk(!rq_valid, "R10 reset rq_valid", rq_valid, 0);
      chk(!done, "R9 reset done", done, 0);
      chk({op_flush, op_fill, op_copy_out, op_direct} == 4'b0, "R11 reset strobes",
          {op_flush, op_fill, op_copy_out, op_direct}, 0);
   endtask

   // R2 R4 R8: translation mismatch without refresh, read miss
   task automatic t_read_miss_noupd;
      int st;
      run_cmd(1'b0, 16'h0012, 1'b1, 1'b0, "R2", st);
      chk_seq("R2 R4 R8 read miss", E_XT_RD, E_WB_RD, E_DIRECT, 0, 0, 0);
      chk(st == 2, "R9 read miss status", st, 2);
      chk(m_xt[2] == '0, "R4 no translation write", m_xt[2], 0);
   endtask

   // R4 R7: refresh, mismatch writes tag and line; write miss fills
   task automatic t_write_upd;
      int st;
      run_cmd(1'b1, 16'h1233, 1'b1, 1'b1, "R4", st);
      chk_seq("R4 R7 write with refresh", E_XT_RD, E_XT_WR, E_XL_WR, E_WB_RD, E_FILL, E_WB_WR);
      chk(st == 2, "R9 write miss status", st, 2);
      chk(m_xt[3] == {2'b10, 13'h0246}, "R4 translation tag word", m_xt[3], {2'b10, 13'h0246});
      chk(m_xl[3] == {2'b10, 13'h0246}, "R4 translation line word", m_xl[3], {2'b10, 13'h0246});
      chk(m_wb[3] == {2'b11, 13'h0246}, "R7 wb tag written", m_wb[3], {2'b11, 13'h0246});
   endtask

   // R3 R8: translation match, read hit
   task automatic t_read_hit;
      int st;
      run_cmd(1'b0, 16'h1233, 1'b1, 1'b0, "R3", st);
      chk_seq("R3 R8 read hit", E_XT_RD, E_XL_RD, E_WB_RD, E_COPY, 0, 0);
      chk(st == 1, "R9 read hit status", st, 1);
   endtask

   // R5 R6 R7: dirty conflict on write, translation skipped
   task automatic t_write_flush;
      int st;
      run_cmd(1'b1, 16'h4563, 1'b0, 1'b0, "R6", st);
      chk_seq("R5 R6 R7 flush then fill", E_WB_RD, E_FLUSH, E_FILL, E_WB_WR, 0, 0);
      chk(flush_tag_seen == 13'h0246, "R6 victim tag", flush_tag_seen, 13'h0246);
      chk(st == 3, "R9 flushed status", st, 3);
      chk(m_wb[3] == {2'b11, 13'h08AC}, "R7 new wb tag", m_wb[3], {2'b11, 13'h08AC});
   endtask

   // R6 R7: clean conflict needs no flush; then write hit
   task automatic t_write_clean_then_hit;
      int st;
      m_wb[5] = {2'b10, 13'h0111};
      run_cmd(1'b1, {13'h0AAA, 3'd5}, 1'b0, 1'b0, "R6", st);
      chk_seq("R6 clean conflict no flush", E_WB_RD, E_FILL, E_WB_WR, 0, 0, 0);
      chk(st == 2, "R9 clean conflict status", st, 2);
      run_cmd(1'b1, {13'h0AAA, 3'd5}, 1'b0, 1'b0, "R7", st);
      chk_seq("R7 write hit", E_WB_RD, E_FILL, E_WB_WR, 0, 0, 0);
      chk(st == 1, "R9 write hit status", st, 1);
      chk(m_wb[5] == {2'b11, 13'h0AAA}, "R7 wb tag dirty", m_wb[5], {2'b11, 13'h0AAA});
   endtask

   // R8: read of a set whose line holds another tag goes direct
   task automatic t_read_other_tag;
      int st;
      run_cmd(1'b0, {13'h0BBB, 3'd5}, 1'b0, 1'b0, "R8", st);
      chk_seq("R8 read tag differs", E_WB_RD, E_DIRECT, 0, 0, 0, 0);
      chk(st == 2, "R9 read other tag status", st, 2);
      chk(m_wb[5] == {2'b11, 13'h0AAA}, "R8 read leaves wb tag", m_wb[5], {2'b11, 13'h0AAA});
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_xt[i] = '0; m_xl[i] = '0; m_wb[i] = '0;
      end
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_read_miss_noupd;
      t_write_upd;
      t_read_hit;
      t_write_flush;
      t_write_clean_then_hit;
      t_read_other_tag;
      chk(viol_hold == 0, "R10 request held while stalled", viol_hold, 0);
      chk(viol_out == 0, "R10 one request outstanding", viol_out, 0);
      chk(viol_strb == 0, "R11 strobe width and exclusivity", viol_strb, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule